// File: doc/BRIEF.md
# Indexed-Access Prioritized Interrupt Controller

This block gathers a parameterized vector of system interrupt inputs, from a few up to 1024, and presents them to one host processor through a single active-low interrupt output. Each source is given its own trigger mode (level high, level low, rising edge or falling edge), its own latched status, its own enable and its own priority channel. Software sets and clears enables, and clears statuses, either by writing a single source number to an index register or by writing a bitmask. It finds the source to service by reading one prioritized-index register. Bits 9:0 of that register hold the winning source number, and bit 31 flags that nothing is pending.

Access is through a plain 32-bit register bus with byte offsets and a one-cycle write strobe. Reads are combinational from the current register state. Source priority is resolved combinationally: the lowest channel number wins, and among sources on the same channel the lowest source number wins.

The host output is owned by a two-state machine. In `HOST_QUIET` the output is high. The transition RAISE, taken when the global enable, the interrupt host enable and at least one pending-and-enabled source are all present, moves it to `HOST_RAISED`, where the output is low. The transition DROP, taken as soon as any of the three goes away, returns it to `HOST_QUIET`. In each state, a cycle with no change keeps the machine where it is.

Top module: `ixc_top`

## Requirements
- R1: After reset, offset 0x080 reads 0x8000_0000. The output `irq_n_o` is high, and every enable, status, polarity-0, type and channel field reads back as reset (all polarity bits 1, all other fields 0).
- R2: A source whose type bit is 0 sets its status on every cycle that its input equals its polarity bit (1 = active high, 0 = active low). Clearing the status while the input stays active leaves it set. Polarity words live at 0x0D00 + 4·n and type words at 0x0D80 + 4·n, with source k at bit k mod 32 of word k/32, and both read back.
- R3: A source whose type bit is 1 sets its status only on an input transition: a rising edge when the polarity bit is 1, a falling edge when it is 0. The status then stays set when the input returns, and an input that stays high after a clear does not set it again.
- R4: Writing a source number to 0x024 clears only that source's status. Writing a word to 0x0280 + 4·n clears the status of every source whose bit is 1 in that word. The same words read back the raw status.
- R5: When a clear of a source's status and a new trigger on that source fall in the same cycle, the status ends up set.
- R6: Writing a source number to 0x028 sets its enable, and writing it to 0x02C clears its enable. Writing a word to 0x0380 + 4·n clears the enables whose bits are 1, and that word reads back the enables.
- R7: The word at 0x0400 + 4·n holds channels for sources 4n..4n+3, with byte b (bits 8b+7:8b) belonging to source 4n+b. Any 8-bit value, 7 included, is legal and reads back.
- R8: Offset 0x080 returns, in bits 9:0, the source that is both pending and enabled and has the lowest channel, with the lowest source number winning a tie. When no such source exists it returns 0x8000_0000. Sources that are pending but not enabled never appear.
- R9: Offset 0x010 bit 0 is the global enable. Writing host number h to 0x034 sets host enable bit h, and writing it to 0x038 clears that bit. The host enable bitmask is read and written at 0x1500, and host 1 is the interrupt output.
- R10: `irq_n_o` goes low one cycle after global enable, host 1 enable and a pending enabled source are all present together. It goes high one cycle after any of the three is removed.
- R11: Reads of unimplemented offsets return 0. Index writes whose value is at or above the source count (or the host count) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 13 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_src_i | input | NUM_SRC | Raw system interrupt inputs, synchronous to `clk` |
| irq_n_o | output | 1 | Active-low host interrupt output (host 1) |

## Verification
The collision that matters is a status clear and a new trigger on the same source in one cycle. This happens either through an index clear of an edge source whose input rises in the same cycle, or through a clear of a level source whose input is still active. The bench provokes both. It drives the input edge and the clear write in the same low clock phase, so both are sampled by the same rising edge. It then reads the status word and requires the bit to remain set. The cases where the clear lands without a competing trigger are checked alongside, to show the clear itself works.

// File: rtl/ixc_pkg.sv
package ixc_pkg;

    localparam int unsigned ADDR_W = 13;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 10;
    localparam int unsigned CH_W   = 8;

    localparam int OFS_GLOBAL_EN   = 'h0010;
    localparam int OFS_STAT_IDXCLR = 'h0024;
    localparam int OFS_EN_IDXSET   = 'h0028;
    localparam int OFS_EN_IDXCLR   = 'h002C;
    localparam int OFS_HOST_IDXSET = 'h0034;
    localparam int OFS_HOST_IDXCLR = 'h0038;
    localparam int OFS_PRIO_IDX    = 'h0080;
    localparam int OFS_STAT_MASK   = 'h0280;
    localparam int OFS_EN_MASK     = 'h0380;
    localparam int OFS_CHMAP       = 'h0400;
    localparam int OFS_POLARITY    = 'h0D00;
    localparam int OFS_TRIGTYPE    = 'h0D80;
    localparam int OFS_HOST_EN     = 'h1500;

    localparam int HOST_IRQ_SLOT = 1;

    typedef enum logic {
        HOST_QUIET  = 1'b0,
        HOST_RAISED = 1'b1
    } host_state_e;

endpackage

// File: rtl/ixc_src_bank.sv
module ixc_src_bank #(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [NUM_SRC-1:0] pol_i,
    input  logic [NUM_SRC-1:0] typ_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] stat_o
);

    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] stat_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        logic edge_hit;
        logic lvl_hit;
        logic trig;

        always_comb begin
            edge_hit = pol_i[g] ? (irq_i[g] & ~prev_q[g]) : (~irq_i[g] & prev_q[g]);
            lvl_hit  = ~(irq_i[g] ^ pol_i[g]);
            trig     = typ_i[g] ? edge_hit : lvl_hit;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                stat_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= irq_i[g];
                // a new trigger outranks a clear in the same cycle
                stat_q[g] <= trig | (stat_q[g] & ~clr_i[g]);
            end
        end

        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[g] && !clr_i[g]) |=> stat_q[g]);

        p_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!typ_i[g] && (irq_i[g] == pol_i[g])) |=> stat_q[g]);

        p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (typ_i[g] && pol_i[g] && irq_i[g] && !prev_q[g]) |=> stat_q[g]);

        p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !typ_i[g] && (irq_i[g] == pol_i[g])) |=> stat_q[g]);
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/ixc_prio_pick.sv
module ixc_prio_pick
    import ixc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0][CH_W-1:0]  ch_i,
    output logic [IDX_W-1:0]              win_o,
    output logic                          none_o
);

    localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic            found;
    logic [CH_W-1:0] best_ch;
    logic [IDX_W-1:0] win;

    // linear scan: strict "less than" keeps the lower source on a channel tie
    always_comb begin
        found   = 1'b0;
        best_ch = '1;
        win     = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (pend_i[k] && (!found || (ch_i[k] < best_ch))) begin
                found   = 1'b1;
                best_ch = ch_i[k];
                win     = IDX_W'(k);
            end
        end
    end

    assign win_o  = win;
    assign none_o = ~found;

    p_win_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !none_o |-> pend_i[win_o[SEL_W-1:0]]);

    p_none_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        none_o |-> (pend_i == '0));

    p_none_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        none_o |-> (win_o == '0));

endmodule

// File: rtl/ixc_host_fsm.sv
module ixc_host_fsm
    import ixc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic glb_en_i,
    input  logic host_en_i,
    input  logic any_pend_i,
    output logic irq_n_o
);

    host_state_e state_q;
    host_state_e state_d;
    logic        want;

    assign want = glb_en_i & host_en_i & any_pend_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOST_QUIET:  if (want)  state_d = HOST_RAISED;
            HOST_RAISED: if (!want) state_d = HOST_QUIET;
            default:                state_d = HOST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            HOST_RAISED: irq_n_o = 1'b0;
            default:     irq_n_o = 1'b1;
        endcase
    end

    p_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_i && host_en_i && any_pend_i) |=> !irq_n_o);

    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(glb_en_i && host_en_i && any_pend_i) |=> irq_n_o);

endmodule

// File: rtl/ixc_top.sv
module ixc_top
    import ixc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 64,
    parameter int unsigned NUM_HOST = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [12:0]        bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [NUM_SRC-1:0] irq_src_i,
    output logic               irq_n_o
);

    localparam int unsigned NWORD = (NUM_SRC + 31) / 32;
    localparam int unsigned NMAP  = (NUM_SRC + 3) / 4;
    localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned HSL_W = (NUM_HOST > 1) ? $clog2(NUM_HOST) : 1;

    logic                          glb_en_q;
    logic [NUM_HOST-1:0]           host_en_q;
    logic [NUM_SRC-1:0]            en_q;
    logic [NUM_SRC-1:0]            pol_q;
    logic [NUM_SRC-1:0]            typ_q;
    logic [NUM_SRC-1:0][CH_W-1:0]  ch_q;
    logic [NUM_SRC-1:0]            stat;
    logic [NUM_SRC-1:0]            stat_clr;
    logic [NUM_SRC-1:0]            pend;
    logic [IDX_W-1:0]              win;
    logic                          none;

    function automatic logic hit(input logic [12:0] a, input int ofs);
        return a == 13'(ofs);
    endfunction

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en_q  <= 1'b0;
            host_en_q <= '0;
            en_q      <= '0;
            pol_q     <= '1;
            typ_q     <= '0;
            ch_q      <= '0;
        end else if (bus_wr_i) begin
            if (hit(bus_addr_i, OFS_GLOBAL_EN))
                glb_en_q <= bus_wdata_i[0];
            if (hit(bus_addr_i, OFS_HOST_EN))
                host_en_q <= bus_wdata_i[NUM_HOST-1:0];
            for (int h = 0; h < NUM_HOST; h++) begin
                if (hit(bus_addr_i, OFS_HOST_IDXSET) && bus_wdata_i == 32'(h))
                    host_en_q[h] <= 1'b1;
                if (hit(bus_addr_i, OFS_HOST_IDXCLR) && bus_wdata_i == 32'(h))
                    host_en_q[h] <= 1'b0;
            end
            for (int k = 0; k < NUM_SRC; k++) begin
                if (hit(bus_addr_i, OFS_EN_IDXSET) && bus_wdata_i == 32'(k))
                    en_q[k] <= 1'b1;
                if (hit(bus_addr_i, OFS_EN_IDXCLR) && bus_wdata_i == 32'(k))
                    en_q[k] <= 1'b0;
                if (hit(bus_addr_i, OFS_EN_MASK + 4 * (k / 32)) && bus_wdata_i[k % 32])
                    en_q[k] <= 1'b0;
                if (hit(bus_addr_i, OFS_POLARITY + 4 * (k / 32)))
                    pol_q[k] <= bus_wdata_i[k % 32];
                if (hit(bus_addr_i, OFS_TRIGTYPE + 4 * (k / 32)))
                    typ_q[k] <= bus_wdata_i[k % 32];
                if (hit(bus_addr_i, OFS_CHMAP + 4 * (k / 4)))
                    ch_q[k] <= bus_wdata_i[8 * (k % 4) +: 8];
            end
        end
    end

    // ---------------- status clear decode ----------------
    always_comb begin
        for (int k = 0; k < NUM_SRC; k++) begin
            stat_clr[k] = bus_wr_i &&
                ((hit(bus_addr_i, OFS_STAT_IDXCLR) && bus_wdata_i == 32'(k)) ||
                 (hit(bus_addr_i, OFS_STAT_MASK + 4 * (k / 32)) && bus_wdata_i[k % 32]));
        end
    end

    ixc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_src_i),
        .pol_i  (pol_q),
        .typ_i  (typ_q),
        .clr_i  (stat_clr),
        .stat_o (stat)
    );

    assign pend = stat & en_q;

    ixc_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .ch_i   (ch_q),
        .win_o  (win),
        .none_o (none)
    );

    ixc_host_fsm u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_en_i   (glb_en_q),
        .host_en_i  (host_en_q[HOST_IRQ_SLOT]),
        .any_pend_i (|pend),
        .irq_n_o    (irq_n_o)
    );

    // ---------------- read mux ----------------
    logic [NWORD*32-1:0]          stat_pad;
    logic [NWORD*32-1:0]          en_pad;
    logic [NWORD*32-1:0]          pol_pad;
    logic [NWORD*32-1:0]          typ_pad;
    logic [NMAP*4-1:0][CH_W-1:0]  ch_pad;

    always_comb begin
        stat_pad = '0;
        en_pad   = '0;
        pol_pad  = '0;
        typ_pad  = '0;
        ch_pad   = '0;
        stat_pad[NUM_SRC-1:0] = stat;
        en_pad[NUM_SRC-1:0]   = en_q;
        pol_pad[NUM_SRC-1:0]  = pol_q;
        typ_pad[NUM_SRC-1:0]  = typ_q;
        ch_pad[NUM_SRC-1:0]   = ch_q;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (hit(bus_addr_i, OFS_GLOBAL_EN))
            bus_rdata_o[0] = glb_en_q;
        if (hit(bus_addr_i, OFS_HOST_EN))
            bus_rdata_o[NUM_HOST-1:0] = host_en_q;
        if (hit(bus_addr_i, OFS_PRIO_IDX))
            bus_rdata_o = {none, 21'd0, win};
        for (int w = 0; w < NWORD; w++) begin
            if (hit(bus_addr_i, OFS_STAT_MASK + 4 * w)) bus_rdata_o = stat_pad[32 * w +: 32];
            if (hit(bus_addr_i, OFS_EN_MASK + 4 * w))   bus_rdata_o = en_pad[32 * w +: 32];
            if (hit(bus_addr_i, OFS_POLARITY + 4 * w))  bus_rdata_o = pol_pad[32 * w +: 32];
            if (hit(bus_addr_i, OFS_TRIGTYPE + 4 * w))  bus_rdata_o = typ_pad[32 * w +: 32];
        end
        for (int w = 0; w < NMAP; w++) begin
            if (hit(bus_addr_i, OFS_CHMAP + 4 * w)) bus_rdata_o = ch_pad[4 * w +: 4];
        end
    end

    // ---------------- assertions ----------------
    p_en_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && hit(bus_addr_i, OFS_EN_IDXSET) && bus_wdata_i < 32'(NUM_SRC))
        |=> en_q[$past(bus_wdata_i[SEL_W-1:0])]);

    p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && hit(bus_addr_i, OFS_EN_IDXCLR) && bus_wdata_i < 32'(NUM_SRC))
        |=> !en_q[$past(bus_wdata_i[SEL_W-1:0])]);

    p_glb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && hit(bus_addr_i, OFS_GLOBAL_EN)) |=> (glb_en_q == $past(bus_wdata_i[0])));

    p_host_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && hit(bus_addr_i, OFS_HOST_IDXSET) && bus_wdata_i < 32'(NUM_HOST))
        |=> host_en_q[$past(bus_wdata_i[HSL_W-1:0])]);

    p_oob_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && (hit(bus_addr_i, OFS_EN_IDXSET) || hit(bus_addr_i, OFS_EN_IDXCLR))
         && bus_wdata_i >= 32'(NUM_SRC)) |=> $stable(en_q));

endmodule

// File: tb/ixc_top_bench.sv
module ixc_top_bench;

    localparam int NSRC = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [12:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] irq_src = '0;
    logic            irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ixc_top #(.NUM_SRC(NSRC), .NUM_HOST(2)) u_ixc_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_wr_i    (bus_wr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_src_i   (irq_src),
        .irq_n_o     (irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [12:0] a, input logic [31:0] exp);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_irq(input int k, input logic v);
        @(negedge clk);
        irq_src[k] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 prio idx after reset", 13'h080, 32'h8000_0000);
        chk("R1 irq_n after reset", {31'd0, irq_n}, 32'd1);
        rd_chk("R1 enables after reset", 13'h380, 32'h0);
        rd_chk("R1 polarity after reset", 13'hD00, 32'hFFFF_FFFF);
        rd_chk("R1 global after reset", 13'h010, 32'h0);
    endtask

    task automatic t_level();
        wr(13'h028, 32'd3);
        set_irq(3, 1'b1);
        rd_chk("R2 level high latches", 13'h280, 32'h0000_0008);
        rd_chk("R8 single winner", 13'h080, 32'd3);
        wr(13'h024, 32'd3);
        rd_chk("R5 level clear while active stays set", 13'h280, 32'h0000_0008);
        set_irq(3, 1'b0);
        wr(13'h024, 32'd3);
        rd_chk("R4 index clear after level drops", 13'h280, 32'h0);
        wr(13'h02C, 32'd3);
        wr(13'hD00, ~(32'h1 << 5));
        tick();
        rd_chk("R2 level low latches", 13'h280, 32'h0000_0020);
        rd_chk("R2 polarity readback", 13'hD00, 32'hFFFF_FFDF);
        wr(13'hD00, 32'hFFFF_FFFF);
        wr(13'h024, 32'd5);
        rd_chk("R2 level low cleared after restore", 13'h280, 32'h0);
    endtask

    task automatic t_edge();
        wr(13'hD80, 32'h0000_0C00);
        wr(13'hD00, ~(32'h1 << 11));
        rd_chk("R3 type readback", 13'hD80, 32'h0000_0C00);
        rd_chk("R3 no status from config", 13'h280, 32'h0);
        set_irq(10, 1'b1);
        rd_chk("R3 rising edge latches", 13'h280, 32'h0000_0400);
        wr(13'h024, 32'd10);
        rd_chk("R3 edge no relatch while high", 13'h280, 32'h0);
        set_irq(10, 1'b0);
        rd_chk("R3 falling ignored on rising source", 13'h280, 32'h0);
        set_irq(10, 1'b1);
        set_irq(10, 1'b0);
        rd_chk("R3 edge status held after input drops", 13'h280, 32'h0000_0400);
        set_irq(11, 1'b1);
        rd_chk("R3 rise ignored on falling source", 13'h280, 32'h0000_0400);
        set_irq(11, 1'b0);
        rd_chk("R3 falling edge latches", 13'h280, 32'h0000_0C00);
    endtask

    task automatic t_mask_clear();
        set_irq(40, 1'b1);
        set_irq(40, 1'b0);
        rd_chk("R4 word1 status", 13'h284, 32'h0000_0100);
        wr(13'h280, 32'h0000_0400);
        rd_chk("R4 mask clear one bit", 13'h280, 32'h0000_0800);
        wr(13'h284, 32'h0000_0100);
        rd_chk("R4 mask clear word1", 13'h284, 32'h0);
        wr(13'h280, 32'hFFFF_FFFF);
        rd_chk("R4 mask clear all", 13'h280, 32'h0);
    endtask

    task automatic t_collide();
        set_irq(10, 1'b1);
        set_irq(10, 1'b0);
        rd_chk("R5 pre-collision status", 13'h280, 32'h0000_0400);
        @(negedge clk);
        irq_src[10] = 1'b1;
        bus_addr    = 13'h024;
        bus_wdata   = 32'd10;
        bus_wr      = 1'b1;
        @(negedge clk);
        bus_wr      = 1'b0;
        rd_chk("R5 edge and clear same cycle keeps status", 13'h280, 32'h0000_0400);
        set_irq(10, 1'b0);
        wr(13'h024, 32'd10);
        rd_chk("R5 later clear alone works", 13'h280, 32'h0);
        wr(13'hD80, 32'h0);
        wr(13'hD00, 32'hFFFF_FFFF);
        wr(13'h280, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable();
        wr(13'h028, 32'd7);
        wr(13'h028, 32'd33);
        rd_chk("R6 enable set word0", 13'h380, 32'h0000_0080);
        rd_chk("R6 enable set word1", 13'h384, 32'h0000_0002);
        wr(13'h02C, 32'd7);
        rd_chk("R6 enable index clear", 13'h380, 32'h0);
        wr(13'h384, 32'h0000_0002);
        rd_chk("R6 enable mask clear", 13'h384, 32'h0);
        wr(13'h028, 32'd64);
        wr(13'h028, 32'd999);
        rd_chk("R11 oob enable word0", 13'h380, 32'h0);
        rd_chk("R11 oob enable word1", 13'h384, 32'h0);
    endtask

    task automatic t_prio();
        wr(13'h414, 32'h0702_0205);
        rd_chk("R7 channel map readback", 13'h414, 32'h0702_0205);
        wr(13'h028, 32'd20);
        wr(13'h028, 32'd21);
        wr(13'h028, 32'd22);
        @(negedge clk);
        irq_src[22:20] = 3'b111;
        irq_src[30]    = 1'b1;
        @(negedge clk);
        rd_chk("R8 lowest channel then lowest source", 13'h080, 32'd21);
        wr(13'h02C, 32'd21);
        rd_chk("R8 next in same channel", 13'h080, 32'd22);
        wr(13'h02C, 32'd22);
        rd_chk("R7 byte0 channel 5 wins alone", 13'h080, 32'd20);
        wr(13'h028, 32'd2);
        set_irq(2, 1'b1);
        rd_chk("R8 channel 0 beats channel 5", 13'h080, 32'd2);
        wr(13'h02C, 32'd2);
        wr(13'h02C, 32'd20);
        rd_chk("R8 pending but disabled gives none", 13'h080, 32'h8000_0000);
        @(negedge clk);
        irq_src = '0;
        wr(13'h280, 32'hFFFF_FFFF);
        rd_chk("R8 cleanup status", 13'h280, 32'h0);
    endtask

    task automatic t_host();
        wr(13'h028, 32'd3);
        set_irq(3, 1'b1);
        tick();
        chk("R10 no output without global", {31'd0, irq_n}, 32'd1);
        wr(13'h010, 32'd1);
        rd_chk("R9 global readback", 13'h010, 32'd1);
        tick();
        chk("R10 no output without host enable", {31'd0, irq_n}, 32'd1);
        wr(13'h034, 32'd1);
        chk("R10 output one cycle late", {31'd0, irq_n}, 32'd1);
        tick();
        chk("R10 output asserted", {31'd0, irq_n}, 32'd0);
        rd_chk("R9 host bitmask after index set", 13'h1500, 32'd2);
        wr(13'h038, 32'd1);
        tick();
        chk("R10 host index clear drops output", {31'd0, irq_n}, 32'd1);
        wr(13'h1500, 32'd2);
        rd_chk("R9 host bitmask write", 13'h1500, 32'd2);
        tick();
        chk("R10 bitmask host enable raises", {31'd0, irq_n}, 32'd0);
        wr(13'h010, 32'd0);
        tick();
        chk("R10 global off drops output", {31'd0, irq_n}, 32'd1);
        wr(13'h010, 32'd1);
        tick();
        set_irq(3, 1'b0);
        wr(13'h024, 32'd3);
        tick();
        chk("R10 no pending drops output", {31'd0, irq_n}, 32'd1);
    endtask

    task automatic t_unmapped();
        rd_chk("R11 unimplemented 0x200", 13'h200, 32'h0);
        rd_chk("R11 unimplemented 0x1504", 13'h1504, 32'h0);
        rd_chk("R11 unimplemented 0x004", 13'h004, 32'h0);
        wr(13'h034, 32'd5);
        rd_chk("R11 oob host index ignored", 13'h1500, 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_edge();
        t_mask_clear();
        t_collide();
        t_enable();
        t_prio();
        t_host();
        t_unmapped();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule